// File: doc/BRIEF.md
# Credit-Flow Configurable Functional Unit

This block is one compute tile of a circuit-switched dataflow array. Four neighbouring switch ports each offer a data word with a forward valid bit. A configuration word, shifted in one bit per cycle, picks which two of those ports supply the operands and which arithmetic or logic function the tile applies.

The tile fires when everything it needs is present: both selected operands are valid and the downstream receiver has room. A firing writes the result into an output data register. The tile then raises the output valid bit for one cycle and pulses a credit back to each port it consumed from.

Downstream room is tracked with a credit counter. The counter starts at the depth of the downstream buffer. It loses one per result sent and gains one for each credit that comes back. A status register reports three things: whether a configuration is loaded, whether a load is partly shifted in, and the carry out of the most recent addition. A loaded configuration serves any number of firings until a new one is shifted in.

Top module: `dfu_tile`

## Requirements
- R1: After reset, out_valid, in_credit and all status bits are 0, and the tile never fires until a full configuration has been loaded.
- R2: A configuration is 64 bits, shifted in least significant bit first on cfg_bit while cfg_en is high. The fields are: bits [3:0] the function code, bits [5:4] the port for operand A, bits [7:6] the port for operand B. status bit 0 (configured) is 1 from the cycle after the 64th bit and stays 1 until a new load starts.
- R3: While cfg_en is high the tile does not fire. status bit 1 (busy) is 1 after the first bit of a load has been shifted and until the 64th, and configured reads 0 during the load.
- R4: The tile fires only in a cycle where it is configured, cfg_en is low, in_valid is high on both selected ports, and the output credit count is nonzero.
- R5: In a firing cycle, in_credit pulses high in the same cycle on exactly the selected ports: two bits when A and B differ, one bit when they name the same port. It is 0 in all other cycles.
- R6: out_valid is high for exactly the cycle after a firing, and out_data then holds the result computed from the operands sampled at the firing. out_data holds its value between firings.
- R7: The output credit count resets to 2, drops by one per firing and rises by one per out_credit_ret pulse. With no credits returned, at most two results are sent before the tile stalls.
- R8: Function codes: 0 gives A+B, 1 gives A-B, 2 gives A AND B, 3 gives A OR B, 4 gives A XOR B, 5 passes A. Every other code gives 0. All results are truncated to the data width.
- R9: status bit 2 is the carry out of the most recent firing with code 0. Firings with other codes, and configuration loads, leave it unchanged.
- R10: A loaded configuration stays in force for every later firing until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_bit | input | 1 | Serial configuration bit |
| in_data | input | 64 | Four 16-bit port words; port p occupies bits [16p+15:16p] |
| in_valid | input | 4 | Forward valid bit for each port |
| in_credit | output | 4 | Credit pulse back to each port |
| out_data | output | 16 | Result register |
| out_valid | output | 1 | Result valid, one cycle per firing |
| out_credit_ret | input | 1 | Credit returned by the downstream receiver |
| status | output | 3 | bit 0 configured, bit 1 busy, bit 2 addition carry |

## Verification
The bench drains the output credits with no returns. A counter with the wrong reset value or the wrong direction would send a third result, or would stall too early. It also returns a credit in a cycle where the count is zero. A design that lets that credit bypass the register would fire in that same cycle.

Loads start while every port is valid, to show that firing is held off. A configuration with both operands on one port exposes a design that pulses two credits, or that pulses the wrong port. Additions that wrap set the carry flag, and then subtraction firings and a reload must leave it alone. A design that cleared the flag on those would show up in status bit 2.

// File: rtl/dfu_pkg.sv
`timescale 1ns/1ps
package dfu_pkg;
  localparam int CFG_W   = 64;
  localparam int FIELD_W = 8;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_PASS = 4'd5
  } dfu_op_e;

  typedef struct packed {
    logic [1:0] sel_b;
    logic [1:0] sel_a;
    logic [3:0] op;
  } dfu_field_t;
endpackage

// File: rtl/dfu_cfg_shift.sv
`timescale 1ns/1ps
module dfu_cfg_shift #(
  parameter int W  = 64,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_bit,
  output logic [FW-1:0] field,
  output logic          configured_q,
  output logic          busy_q
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          conf_d, busy_d, last;

  assign last  = (cnt_q == CW'(W-1));
  assign field = sh_q[FW-1:0];

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    conf_d = configured_q;
    busy_d = busy_q;
    if (cfg_en) begin
      sh_d   = {cfg_bit, sh_q[W-1:1]};
      cnt_d  = last ? '0 : cnt_q + 1'b1;
      conf_d = last;
      busy_d = !last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q         <= '0;
      cnt_q        <= '0;
      configured_q <= 1'b0;
      busy_q       <= 1'b0;
    end else begin
      sh_q         <= sh_d;
      cnt_q        <= cnt_d;
      configured_q <= conf_d;
      busy_q       <= busy_d;
    end
  end

  // R2
  conf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(configured_q) |-> $past(cfg_en));

  // R3
  conf_low_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !configured_q);
endmodule

// File: rtl/dfu_credit_ctr.sv
`timescale 1ns/1ps
module dfu_credit_ctr #(
  parameter int DEPTH = 2,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            give,
  output logic            avail,
  output logic [CNTW-1:0] count_q
);
  logic [CNTW-1:0] count_d;

  assign avail = (count_q != '0);

  always_comb begin
    count_d = count_q;
    case ({take, give})
      2'b10:   count_d = count_q - 1'b1;
      2'b01:   count_d = count_q + 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= CNTW'(DEPTH);
    else        count_q <= count_d;
  end

  // R7
  cred_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNTW'(DEPTH));

  // R4
  take_has_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> count_q != '0);
endmodule

// File: rtl/dfu_alu.sv
`timescale 1ns/1ps
module dfu_alu
  import dfu_pkg::*;
#(
  parameter int DW = 16
) (
  input  dfu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          carry
);
  logic [DW:0] sum;

  assign sum   = {1'b0, a} + {1'b0, b};
  assign carry = sum[DW];

  always_comb begin
    case (op)
      OP_ADD:  y = sum[DW-1:0];
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_PASS: y = a;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/dfu_tile.sv
`timescale 1ns/1ps
module dfu_tile
  import dfu_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NPORT = 4,
  parameter int DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic               cfg_bit,
  input  logic [NPORT*DW-1:0] in_data,
  input  logic [NPORT-1:0]   in_valid,
  output logic [NPORT-1:0]   in_credit,
  output logic [DW-1:0]      out_data,
  output logic               out_valid,
  input  logic               out_credit_ret,
  output logic [2:0]         status
);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [DW-1:0]    port_d [NPORT];
  dfu_field_t       fld;
  logic             configured, busy, avail, fire, ready, carry;
  logic [NPORT-1:0] need;
  logic [CNTW-1:0]  cred_cnt;
  logic [DW-1:0]    op_a, op_b, res;
  logic [DW-1:0]    out_data_q, out_data_d;
  logic             out_valid_q, out_valid_d, ovf_q, ovf_d;

  for (genvar g = 0; g < NPORT; g++) begin : g_split
    assign port_d[g] = in_data[g*DW +: DW];
  end

  dfu_cfg_shift #(.W(CFG_W), .FW(FIELD_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .field(fld), .configured_q(configured), .busy_q(busy)
  );

  dfu_credit_ctr #(.DEPTH(DEPTH), .CNTW(CNTW)) u_cred (
    .clk(clk), .rst_n(rst_n), .take(fire), .give(out_credit_ret),
    .avail(avail), .count_q(cred_cnt)
  );

  assign op_a  = port_d[fld.sel_a];
  assign op_b  = port_d[fld.sel_b];
  assign need  = (NPORT'(1) << fld.sel_a) | (NPORT'(1) << fld.sel_b);
  assign ready = &(~need | in_valid);
  assign fire  = configured && !cfg_en && ready && avail;

  dfu_alu #(.DW(DW)) u_alu (
    .op(dfu_op_e'(fld.op)), .a(op_a), .b(op_b), .y(res), .carry(carry)
  );

  always_comb begin
    out_valid_d = fire;
    out_data_d  = fire ? res : out_data_q;
    ovf_d       = (fire && fld.op == OP_ADD) ? carry : ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data_q  <= '0;
      out_valid_q <= 1'b0;
      ovf_q       <= 1'b0;
    end else begin
      out_data_q  <= out_data_d;
      out_valid_q <= out_valid_d;
      ovf_q       <= ovf_d;
    end
  end

  assign in_credit = fire ? need : '0;
  assign out_data  = out_data_q;
  assign out_valid = out_valid_q;
  assign status    = {ovf_q, busy, configured};

  // R3
  no_fire_loading_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> in_credit == '0);

  // R5
  credit_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_credit & ~in_valid) == '0) && ($countones(in_credit) <= 2));

  // R6
  out_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_credit != '0) |=> out_valid);

  // R1
  no_out_unconfigured_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status[0] |=> !out_valid);

  // R9
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_credit == '0) |=> $stable(status[2]));
endmodule

// File: tb/test_dfu_tile.sv
`timescale 1ns/1ps
module test_dfu_tile;
  logic        clk, rst_n, cfg_en, cfg_bit, out_valid, out_credit_ret;
  logic [63:0] in_data;
  logic [3:0]  in_valid, in_credit;
  logic [15:0] out_data;
  logic [2:0]  status;

  int total = 0, bad = 0;
  bit done = 0;

  bit       m_conf = 0, m_ovf = 0;
  int       m_cred = 2;
  int       m_op = 0, m_sa = 0, m_sb = 0;

  dfu_tile i_dfu_tile (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .in_data(in_data), .in_valid(in_valid), .in_credit(in_credit),
    .out_data(out_data), .out_valid(out_valid),
    .out_credit_ret(out_credit_ret), .status(status)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [15:0] exp_res(int op, logic [15:0] a, logic [15:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return a;
      default: return 16'h0;
    endcase
  endfunction

  function automatic bit exp_carry(logic [15:0] a, logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[16];
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check credits before edge, outputs after edge
  task automatic step(logic [3:0] v, bit ret, logic [63:0] d, string tag);
    bit          f;
    logic [3:0]  mask;
    logic [15:0] a, b;
    in_valid = v; in_data = d; out_credit_ret = ret;
    #1;
    mask = (4'b1 << m_sa) | (4'b1 << m_sb);
    f = m_conf && ((v & mask) == mask) && (m_cred > 0);
    a = d[m_sa*16 +: 16];
    b = d[m_sb*16 +: 16];
    chk(in_credit == (f ? mask : 4'b0), {"R5 R4 ", tag}, in_credit, f ? mask : 4'b0);
    @(posedge clk); #2;
    m_cred = m_cred - int'(f) + int'(ret);
    if (f && m_op == 0) m_ovf = exp_carry(a, b);
    chk(out_valid == f, {"R6 ", tag}, out_valid, f);
    if (f) chk(out_data == exp_res(m_op, a, b), {"R8 R10 ", tag}, out_data, exp_res(m_op, a, b));
    chk(status[2] == m_ovf, {"R9 ", tag}, status[2], m_ovf);
    @(negedge clk);
    out_credit_ret = 0;
  endtask

  task automatic load(int op, int sa, int sb);
    logic [63:0] w;
    w = {$urandom(), 24'h0, 2'(sb), 2'(sa), 4'(op)};
    for (int i = 0; i < 64; i++) begin
      cfg_en = 1; cfg_bit = w[i]; in_valid = 4'hF; in_data = {$urandom(), $urandom()};
      out_credit_ret = 0;
      #1;
      chk(in_credit == 4'b0, "R3 no fire while loading", in_credit, 0);
      @(posedge clk); #2;
      if (i == 20) chk(status[1:0] == 2'b10, "R3 busy mid-load", status, 2'b10);
      @(negedge clk);
    end
    cfg_en = 0; cfg_bit = 0;
    m_conf = 1; m_op = op; m_sa = sa; m_sb = sb;
    chk(status[1:0] == 2'b01, "R2 configured after 64 bits", status, 2'b01);
    chk(status[2] == m_ovf, "R9 carry kept over load", status[2], m_ovf);
  endtask

  task automatic refill();
    while (m_cred < 2) step(4'h0, 1, 64'h0, "R7 refill");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; cfg_en = 0; cfg_bit = 0; in_valid = 0; in_data = 0; out_credit_ret = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1 reset out_valid", out_valid, 0);
    chk(status == 3'b0, "R1 reset status", status, 0);
    chk(in_credit == 4'b0, "R1 reset in_credit", in_credit, 0);
    step(4'hF, 0, {$urandom(), $urandom()}, "R1 unconfigured");

    load(0, 1, 2);
    // R7: two results without returns, then stall
    step(4'hF, 0, {$urandom(), $urandom()}, "R7 first");
    step(4'hF, 0, {$urandom(), $urandom()}, "R7 second");
    step(4'hF, 0, {$urandom(), $urandom()}, "R7 stall");
    chk(m_cred == 0, "R7 model drained", m_cred, 0);
    step(4'hF, 1, {$urandom(), $urandom()}, "R7 return at zero");
    step(4'hF, 0, {$urandom(), $urandom()}, "R7 after return");
    refill();
    // R4: only one selected port valid
    step(4'b0010, 0, {$urandom(), $urandom()}, "R4 partial");
    step(4'b1001, 0, {$urandom(), $urandom()}, "R4 unselected");
    // R9: wrapping addition
    step(4'b0110, 1, 64'h0000_0002_FFFF_0000, "R9 wrap add");
    chk(status[2] == 1'b1, "R9 carry set", status[2], 1);
    refill();

    load(1, 3, 3);
    step(4'b1000, 0, {$urandom(), $urandom()}, "R5 single port");
    step(4'b1000, 1, 64'h0001_0000_0000_0000, "R9 sub keeps carry");
    chk(status[2] == 1'b1, "R9 carry held", status[2], 1);
    refill();

    for (int c = 0; c < 8; c++) begin
      int op;
      op = (c == 6) ? 9 : (c == 7 ? 0 : c);
      load(op, int'($urandom() % 4), int'($urandom() % 4));
      for (int k = 0; k < 150; k++) begin
        bit r;
        r = (m_cred < 2) && ($urandom() % 2 == 1);
        step(4'($urandom()), r, {$urandom(), $urandom()}, "R10 random");
      end
      refill();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule